// File: doc/BRIEF.md
# Decode-Stage Operand Bypass and Load-Use Interlock Control

This block is the hazard-resolution control for a five-stage in-order integer pipeline. The stages run fetch, decode/register read, execute, memory access and write back. While an instruction sits in decode, the block compares each source register number it uses with the destination register numbers of the two older instructions in execute and memory. From these comparisons it picks, per source operand, where the execute stage should take that operand from. The choices are the register file, the execute-stage ALU result, or the value held in the memory stage. The choice is registered, so it travels into execute together with the instruction it belongs to.

Some hazards cannot be covered by a bypass. A load in execute has no data yet, so if its destination is a source of the decode instruction, the block stalls fetch and decode for one cycle and places a bubble (a NOP) into execute. On the following cycle the load has moved to the memory stage and the operand is bypassed from there. Write-back conflicts need no path here, because the register file writes in the first half of a cycle and decode reads the new value in the same cycle.

Top module: `fwd_ctrl_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, both registered select outputs read 2'b00 (register file), and stall and bubble are low when the producer valid flags are low.
- R2: When a used, nonzero decode source equals the destination of a valid, write-enabled, non-load instruction in execute, that operand's select reads 2'b01 on the cycle after the decode inputs were presented.
- R3: When a used, nonzero decode source equals the destination of a valid, write-enabled instruction in memory and execute does not supply it, the select reads 2'b10 one cycle later.
- R4: When both execute and memory would supply the same source, execute (the younger producer) wins and the select reads 2'b01.
- R5: A source or destination of register 0 never produces a match; the select reads 2'b00 and no stall results from it.
- R6: A producer counts only when its valid flag and its write-enable are both set and the decode instruction marks that source as used; otherwise the select reads 2'b00.
- R7: When a valid, write-enabled load in execute has a destination equal to a used, nonzero decode source, stall_fd and bubble_ex are both high in that same cycle, and both selects read 2'b00 on the next cycle.
- R8: When the decode slot is empty (decode valid low), there is no stall and both selects read 2'b00 one cycle later.
- R9: The two source operands are resolved independently: each select depends only on its own source number and use flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dec_valid | input | 1 | Decode slot holds a real instruction |
| dec_rs1 | input | REG_AW | First source register number in decode |
| dec_rs2 | input | REG_AW | Second source register number in decode |
| dec_use_rs1 | input | 1 | Decode instruction reads its first source |
| dec_use_rs2 | input | 1 | Decode instruction reads its second source |
| ex_valid | input | 1 | Execute stage holds a real instruction |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| ex_rd | input | REG_AW | Execute instruction destination register |
| mem_valid | input | 1 | Memory stage holds a real instruction |
| mem_wen | input | 1 | Memory instruction writes a register |
| mem_rd | input | REG_AW | Memory instruction destination register |
| sel_a_x | output | 2 | Registered bypass select for the first operand in execute (00 file, 01 execute, 10 memory) |
| sel_b_x | output | 2 | Registered bypass select for the second operand in execute |
| stall_fd | output | 1 | Hold fetch and decode this cycle |
| bubble_ex | output | 1 | Load a NOP into execute at the next edge |

## Verification
The bench builds the block with REG_AW set to 3, giving eight registers. That shrinks the space enough to sweep every combination of the two decode sources and the two producer destinations, with and without a load in execute. This covers register 0 on every side, all equalities and all priority collisions. A second sweep walks all 256 settings of the use, valid, write-enable, load and decode-valid flags over a set of register patterns. That brings every gating path and the load-use interlock within reach, and the expected selects are worked out arithmetically from the requirements.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    // Widest register number the shared helpers accept.
    localparam int MAX_AW = 8;

    typedef logic [MAX_AW-1:0] reg_w_t;

    // Operand source seen by execute; the codes are decoded by the datapath mux.
    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_EX  = 2'b01,
        FWD_MEM = 2'b10
    } fwd_sel_e;

    // True when an older producer writes the register this source reads.
    function automatic logic dep_hit(
        input reg_w_t rs,
        input reg_w_t rd,
        input logic   use_src,
        input logic   valid,
        input logic   wen
    );
        return use_src && valid && wen && (rd != '0) && (rs == rd);
    endfunction

    // Younger producer first; a load in execute is never a bypass source.
    function automatic fwd_sel_e pick_src(
        input logic ex_hit,
        input logic ex_is_load,
        input logic mem_hit
    );
        if (ex_hit && !ex_is_load) return FWD_EX;
        if (mem_hit)               return FWD_MEM;
        return FWD_RF;
    endfunction

endpackage

// File: rtl/fwd_src_select.sv
module fwd_src_select
    import fwd_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              dec_valid,
    input  logic [REG_AW-1:0] rs,
    input  logic              use_src,
    input  logic              ex_valid,
    input  logic              ex_wen,
    input  logic              ex_load,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              mem_valid,
    input  logic              mem_wen,
    input  logic [REG_AW-1:0] mem_rd,
    output fwd_sel_e          sel,
    output logic              load_hit
);
    timeunit 1ns;
    timeprecision 1ps;

    logic   live;
    logic   ex_hit;
    logic   mem_hit;
    reg_w_t rs_w;
    reg_w_t ex_w;
    reg_w_t mem_w;

    always_comb begin
        rs_w  = reg_w_t'(rs);
        ex_w  = reg_w_t'(ex_rd);
        mem_w = reg_w_t'(mem_rd);
        live  = dec_valid && use_src;
    end

    always_comb begin
        ex_hit   = dep_hit(rs_w, ex_w, live, ex_valid, ex_wen);
        mem_hit  = dep_hit(rs_w, mem_w, live, mem_valid, mem_wen);
        load_hit = ex_hit && ex_load;
        sel      = pick_src(ex_hit, ex_load, mem_hit);
    end

    // R5
    always_comb begin
        x0_never_hit_chk: assert ((rs_w != '0) || (sel == FWD_RF && !load_hit));
    end

endmodule

// File: rtl/fwd_load_stall.sv
module fwd_load_stall #(
    parameter int NUM_SRC = 2
) (
    input  logic [NUM_SRC-1:0] load_hit,
    output logic               stall,
    output logic               bubble
);
    timeunit 1ns;
    timeprecision 1ps;

    always_comb begin
        stall  = |load_hit;
        bubble = |load_hit;
    end

endmodule

// File: rtl/fwd_sel_pipe.sv
module fwd_sel_pipe
    import fwd_pkg::*;
#(
    parameter int NUM_SRC = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     bubble,
    input  fwd_sel_e sel_d [NUM_SRC],
    output fwd_sel_e sel_q [NUM_SRC]
);
    timeunit 1ns;
    timeprecision 1ps;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst || bubble) sel_q[i] <= FWD_RF;
            else               sel_q[i] <= sel_d[i];
        end

        // R7
        bubble_clears_sel_chk: assert property (@(posedge clk) disable iff (rst)
            bubble |=> (sel_q[i] == FWD_RF));
    end

endmodule

// File: rtl/fwd_ctrl_unit.sv
module fwd_ctrl_unit
    import fwd_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dec_valid,
    input  logic [REG_AW-1:0] dec_rs1,
    input  logic [REG_AW-1:0] dec_rs2,
    input  logic              dec_use_rs1,
    input  logic              dec_use_rs2,
    input  logic              ex_valid,
    input  logic              ex_wen,
    input  logic              ex_load,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              mem_valid,
    input  logic              mem_wen,
    input  logic [REG_AW-1:0] mem_rd,
    output logic [1:0]        sel_a_x,
    output logic [1:0]        sel_b_x,
    output logic              stall_fd,
    output logic              bubble_ex
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NUM_SRC = 2;

    logic [REG_AW-1:0]  src_rs  [NUM_SRC];
    logic [NUM_SRC-1:0] src_use;
    logic [NUM_SRC-1:0] load_hit;
    fwd_sel_e           sel_d   [NUM_SRC];
    fwd_sel_e           sel_q   [NUM_SRC];
    logic               stall;
    logic               bubble;

    always_comb begin
        src_rs[0]  = dec_rs1;
        src_rs[1]  = dec_rs2;
        src_use[0] = dec_use_rs1;
        src_use[1] = dec_use_rs2;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_cmp
        fwd_src_select #(.REG_AW(REG_AW)) cmp_i (
            .dec_valid (dec_valid),
            .rs        (src_rs[i]),
            .use_src   (src_use[i]),
            .ex_valid  (ex_valid),
            .ex_wen    (ex_wen),
            .ex_load   (ex_load),
            .ex_rd     (ex_rd),
            .mem_valid (mem_valid),
            .mem_wen   (mem_wen),
            .mem_rd    (mem_rd),
            .sel       (sel_d[i]),
            .load_hit  (load_hit[i])
        );
    end

    fwd_load_stall #(.NUM_SRC(NUM_SRC)) intlk_i (
        .load_hit (load_hit),
        .stall    (stall),
        .bubble   (bubble)
    );

    fwd_sel_pipe #(.NUM_SRC(NUM_SRC)) pipe_i (
        .clk    (clk),
        .rst    (rst),
        .bubble (bubble),
        .sel_d  (sel_d),
        .sel_q  (sel_q)
    );

    always_comb begin
        sel_a_x   = sel_q[0];
        sel_b_x   = sel_q[1];
        stall_fd  = stall;
        bubble_ex = bubble;
    end

    // R7
    stall_needs_load_chk: assert property (@(posedge clk) disable iff (rst)
        stall_fd |-> (ex_load && ex_valid && ex_wen && dec_valid && bubble_ex));

    // R5
    x0_src_a_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_rs1 == '0) |=> (sel_a_x == 2'b00));

    // R8
    empty_decode_chk: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |=> (sel_a_x == 2'b00 && sel_b_x == 2'b00));

    // R4
    ex_priority_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_use_rs1 && dec_rs1 != '0 && ex_valid && ex_wen && !ex_load
         && dec_rs1 == ex_rd && !stall_fd) |=> (sel_a_x == 2'b01));

    // R6
    idle_producers_chk: assert property (@(posedge clk) disable iff (rst)
        (!ex_valid && !mem_valid) |-> !stall_fd ##1 (sel_a_x == 2'b00 && sel_b_x == 2'b00));

endmodule

// File: tb/fwd_ctrl_unit_tb_top.sv
module fwd_ctrl_unit_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          dec_valid = 1'b0;
    logic [AW-1:0] dec_rs1 = '0;
    logic [AW-1:0] dec_rs2 = '0;
    logic          dec_use_rs1 = 1'b0;
    logic          dec_use_rs2 = 1'b0;
    logic          ex_valid = 1'b0;
    logic          ex_wen = 1'b0;
    logic          ex_load = 1'b0;
    logic [AW-1:0] ex_rd = '0;
    logic          mem_valid = 1'b0;
    logic          mem_wen = 1'b0;
    logic [AW-1:0] mem_rd = '0;
    logic [1:0]    sel_a_x;
    logic [1:0]    sel_b_x;
    logic          stall_fd;
    logic          bubble_ex;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    // Expectations carried from one presented cycle to the next.
    bit       have_prev = 1'b0;
    bit [1:0] prev_a, prev_b;
    string    prev_tag_a, prev_tag_b;

    always #10 clk = ~clk;

    fwd_ctrl_unit #(.REG_AW(AW)) dut_i (
        .clk(clk), .rst(rst),
        .dec_valid(dec_valid), .dec_rs1(dec_rs1), .dec_rs2(dec_rs2),
        .dec_use_rs1(dec_use_rs1), .dec_use_rs2(dec_use_rs2),
        .ex_valid(ex_valid), .ex_wen(ex_wen), .ex_load(ex_load), .ex_rd(ex_rd),
        .mem_valid(mem_valid), .mem_wen(mem_wen), .mem_rd(mem_rd),
        .sel_a_x(sel_a_x), .sel_b_x(sel_b_x),
        .stall_fd(stall_fd), .bubble_ex(bubble_ex)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic bit prod_hit(bit [AW-1:0] rs, bit u, bit v, bit w, bit [AW-1:0] rd);
        return dec_valid && u && v && w && rs != 0 && rs == rd;
    endfunction

    task automatic present(input bit [AW-1:0] r1, input bit [AW-1:0] r2,
                           input bit [AW-1:0] xr, input bit [AW-1:0] mr,
                           input bit [7:0] f);
        bit ea, eb, ma, mb, st;
        bit [1:0] xa, xb;
        @(negedge clk);
        if (have_prev) begin
            check(prev_tag_a, "sel_a_x", int'(sel_a_x), int'(prev_a));
            check(prev_tag_b, "sel_b_x", int'(sel_b_x), int'(prev_b));
        end
        dec_rs1 = r1; dec_rs2 = r2; ex_rd = xr; mem_rd = mr;
        dec_use_rs1 = f[0]; dec_use_rs2 = f[1];
        ex_valid = f[2]; ex_wen = f[3]; ex_load = f[4];
        mem_valid = f[5]; mem_wen = f[6]; dec_valid = f[7];
        #2;
        ea = prod_hit(r1, f[0], f[2], f[3], xr);
        eb = prod_hit(r2, f[1], f[2], f[3], xr);
        ma = prod_hit(r1, f[0], f[5], f[6], mr);
        mb = prod_hit(r2, f[1], f[5], f[6], mr);
        st = f[4] && (ea || eb);
        check("R7", "stall_fd", int'(stall_fd), int'(st));
        check("R7", "bubble_ex", int'(bubble_ex), int'(st));
        xa = st ? 2'b00 : (ea && !f[4]) ? 2'b01 : ma ? 2'b10 : 2'b00;
        xb = st ? 2'b00 : (eb && !f[4]) ? 2'b01 : mb ? 2'b10 : 2'b00;
        prev_a = xa; prev_b = xb; have_prev = 1'b1;
        prev_tag_a = tag_of(st, f[7], r1, ea, ma, (r1 == xr) || (r1 == mr));
        prev_tag_b = tag_of(st, f[7], r2, eb, mb, (r2 == xr) || (r2 == mr));
    endtask

    function automatic string tag_of(bit st, bit dv, bit [AW-1:0] rs, bit eh, bit mh, bit raw);
        if (st)            return "R7";
        if (!dv)           return "R8";
        if (rs == 0)       return "R5";
        if (eh && mh)      return "R4";
        if (eh)            return "R2";
        if (mh)            return "R3";
        if (raw)           return "R6";
        return "R9";
    endfunction

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #4000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs during reset with idle inputs
        check("R1", "sel_a_x in reset", int'(sel_a_x), 0);
        check("R1", "sel_b_x in reset", int'(sel_b_x), 0);
        check("R1", "stall_fd in reset", int'(stall_fd), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "sel_a_x after reset", int'(sel_a_x), 0);
        check("R1", "bubble_ex after reset", int'(bubble_ex), 0);

        // Every register combination, all flags set, without and with a load in execute.
        for (int ld = 0; ld < 2; ld++)
            for (int a = 0; a < 8; a++)
                for (int b = 0; b < 8; b++)
                    for (int x = 0; x < 8; x++)
                        for (int m = 0; m < 8; m++)
                            present(AW'(a), AW'(b), AW'(x), AW'(m),
                                    ld[0] ? 8'hFF : 8'hEF);

        // Every flag setting over a set of register patterns.
        for (int f = 0; f < 256; f++)
            for (int p = 0; p < 16; p++)
                present(AW'(p & 3), AW'((p >> 2) & 3), AW'((p >> 1) & 3),
                        AW'((p >> 2) & 3), 8'(f));

        // Load-use then its resolution: the load moves to memory, decode replays.
        present(3'd4, 3'd0, 3'd4, 3'd0, 8'hBD);
        present(3'd4, 3'd0, 3'd0, 3'd4, 8'hE1);
        present(3'd0, 3'd0, 3'd0, 3'd0, 8'h00);
        @(negedge clk);
        check(prev_tag_a, "sel_a_x", int'(sel_a_x), int'(prev_a));
        check(prev_tag_b, "sel_b_x", int'(sel_b_x), int'(prev_b));
        summary();
    end

endmodule